// File: doc/BRIEF.md
# Line Brown-Out and Connection Fault Qualifier

This block decides whether the power stage of an LED driver controller may switch. It watches digitized comparator flags for the line-sense pin and the supply rail, a detector for a missing ground connection, and a current-sense impedance flag. It counts the controller's millisecond tick to time-qualify slow faults, and it samples the impedance flag only on two strobes.

A sustained low line sets the brown-out condition. While brown-out is set, the block raises a request for reduced supply consumption, so the supply capacitor recharges to its start level without first discharging below its off level. Brown-out clears only when the line is above the upper threshold and the supply is above its start level. These are two separate thresholds, which gives hysteresis.

A missing ground must persist before drive is stopped. The fault drops again as soon as the detector clears. A low current-sense impedance seen at a sampling strobe stops operation until the next supply reset. The reset input `rst_n` stands for that supply reset.

Top module: `brownout_pinfault_mon`

## Requirements
- R1: After reset, `run_en` is 1, `recharge_req` is 0 and `fault_code` is 3'b000.
- R2: `fault_code[0]` (brown-out) becomes 1 one clock after the 25th consecutive `ms_tick` during which `vs_below_off` was held high.
- R3: Any clock with `vs_below_off` low restarts the brown-out count from zero, so 24 ticks, a release and 24 more ticks give no brown-out.
- R4: `recharge_req` is 1 in every cycle in which brown-out is set, and 0 otherwise.
- R5: Brown-out clears one clock after `vs_above_on` and `vcc_above_start` are both high. Either flag alone leaves it set.
- R6: `fault_code[1]` (ground open) becomes 1 right after the 200th consecutive tick with `gnd_open_det` high. A gap restarts the count. The fault drops one clock after `gnd_open_det` goes low.
- R7: `cs_imp_low` is sampled only in cycles where `startup_stb` or `maxon_end_stb` is high. If it is high there, `fault_code[2]` (CS short) becomes 1 on the next clock. Outside those cycles it has no effect.
- R8: Once set, `fault_code[2]` stays at 1 until `rst_n` is asserted, whatever the inputs do.
- R9: `run_en` is 1 exactly when all three `fault_code` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low supply reset |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| vs_below_off | input | 1 | Line sense below the lower threshold |
| vs_above_on | input | 1 | Line sense above the upper threshold |
| vcc_above_start | input | 1 | Supply above its start level |
| gnd_open_det | input | 1 | Ground-return fault detector active |
| cs_imp_low | input | 1 | Current-sense pin impedance measured low |
| startup_stb | input | 1 | Start-up sampling strobe |
| maxon_end_stb | input | 1 | Pulse ended by maximum on-time |
| run_en | output | 1 | Switching permitted |
| recharge_req | output | 1 | Reduced-consumption recharge request |
| fault_code | output | 3 | bit0 brown-out, bit1 ground open, bit2 CS short |

## Verification
A stuck or mis-counted qualification counter appears at `fault_code` as a fault that rises one tick early or late. A missed restart shows up as a fault after two short bursts that should each be ignored. Both are visible within one clock of the deciding tick. A brown-out state register that exits on only one of its two conditions drops `recharge_req` and raises `run_en` one clock after that single flag. A CS-short flag that is not sticky falls within one clock of the impedance input clearing. A latch that samples outside the strobes rises the clock after an unstrobed `cs_imp_low`.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int FC_W     = 3;
  localparam int FC_BO    = 0;
  localparam int FC_GND   = 1;
  localparam int FC_CSSHT = 2;

  typedef enum logic {
    LINE_OK  = 1'b0,
    LINE_LOW = 1'b1
  } line_state_e;
endpackage

// File: rtl/bpm_qual_timer.sv
module bpm_qual_timer #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic qual
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!cond)             cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign qual = cond && (cnt == LIM);
endmodule

// File: rtl/bpm_brownout_fsm.sv
module bpm_brownout_fsm
  import bpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic low_qualified,
  input  logic vs_above_on,
  input  logic vcc_above_start,
  output logic brownout,
  output logic recharge_req
);
  line_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      LINE_OK:  if (low_qualified) st_nx = LINE_LOW;
      LINE_LOW: if (vs_above_on && vcc_above_start) st_nx = LINE_OK;
      default:  st_nx = LINE_OK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= LINE_OK;
    else        st <= st_nx;
  end

  assign brownout     = (st == LINE_LOW);
  assign recharge_req = (st == LINE_LOW);
endmodule

// File: rtl/bpm_cs_short_latch.sv
module bpm_cs_short_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic startup_stb,
  input  logic maxon_end_stb,
  input  logic cs_imp_low,
  output logic cs_short
);
  logic sample;
  assign sample = startup_stb || maxon_end_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cs_short <= 1'b0;
    else if (sample && cs_imp_low) cs_short <= 1'b1;
  end
endmodule

// File: rtl/brownout_pinfault_mon.sv
module brownout_pinfault_mon
  import bpm_pkg::*;
#(
  parameter int BO_QUAL_MS  = 25,
  parameter int GND_QUAL_MS = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic            vs_below_off,
  input  logic            vs_above_on,
  input  logic            vcc_above_start,
  input  logic            gnd_open_det,
  input  logic            cs_imp_low,
  input  logic            startup_stb,
  input  logic            maxon_end_stb,
  output logic            run_en,
  output logic            recharge_req,
  output logic [FC_W-1:0] fault_code
);
  logic bo_qual, brownout, gnd_fault, cs_short;

  bpm_qual_timer #(.LIMIT(BO_QUAL_MS)) u_bo_tmr (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .cond(vs_below_off), .qual(bo_qual)
  );

  bpm_qual_timer #(.LIMIT(GND_QUAL_MS)) u_gnd_tmr (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .cond(gnd_open_det), .qual(gnd_fault)
  );

  bpm_brownout_fsm u_bo_fsm (
    .clk(clk), .rst_n(rst_n), .low_qualified(bo_qual),
    .vs_above_on(vs_above_on), .vcc_above_start(vcc_above_start),
    .brownout(brownout), .recharge_req(recharge_req)
  );

  bpm_cs_short_latch u_cs (
    .clk(clk), .rst_n(rst_n), .startup_stb(startup_stb),
    .maxon_end_stb(maxon_end_stb), .cs_imp_low(cs_imp_low), .cs_short(cs_short)
  );

  always_comb begin
    fault_code           = '0;
    fault_code[FC_BO]    = brownout;
    fault_code[FC_GND]   = gnd_fault;
    fault_code[FC_CSSHT] = cs_short;
  end

  assign run_en = !(brownout || gnd_fault || cs_short);
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vs_below_off,
  input logic       vs_above_on,
  input logic       vcc_above_start,
  input logic       gnd_open_det,
  input logic       cs_imp_low,
  input logic       startup_stb,
  input logic       maxon_end_stb,
  input logic       run_en,
  input logic       recharge_req,
  input logic [2:0] fault_code
);
  // R2
  bo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_code[0]) |-> $past(vs_below_off));

  // R4
  recharge_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recharge_req == fault_code[0]);

  // R5
  bo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_code[0]) |-> $past(vs_above_on && vcc_above_start));

  // R6
  gnd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_code[1]) |-> gnd_open_det);

  // R6
  gnd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnd_open_det |=> !fault_code[1]);

  // R7
  cs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_code[2]) |-> $past((startup_stb || maxon_end_stb) && cs_imp_low));

  // R8
  cs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code[2] |=> fault_code[2]);

  // R9
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en == (fault_code == 3'b000));
endmodule

bind brownout_pinfault_mon bpm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vs_below_off(vs_below_off), .vs_above_on(vs_above_on),
  .vcc_above_start(vcc_above_start), .gnd_open_det(gnd_open_det),
  .cs_imp_low(cs_imp_low), .startup_stb(startup_stb), .maxon_end_stb(maxon_end_stb),
  .run_en(run_en), .recharge_req(recharge_req), .fault_code(fault_code)
);

// File: tb/sim_brownout_pinfault_mon.sv
`timescale 1ns/1ps
module sim_brownout_pinfault_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 0, vs_below_off = 0, vs_above_on = 0, vcc_above_start = 0;
  logic gnd_open_det = 0, cs_imp_low = 0, startup_stb = 0, maxon_end_stb = 0;
  logic run_en, recharge_req;
  logic [2:0] fault_code;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brownout_pinfault_mon u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .vs_below_off(vs_below_off),
    .vs_above_on(vs_above_on), .vcc_above_start(vcc_above_start),
    .gnd_open_det(gnd_open_det), .cs_imp_low(cs_imp_low), .startup_stb(startup_stb),
    .maxon_end_stb(maxon_end_stb), .run_en(run_en), .recharge_req(recharge_req),
    .fault_code(fault_code)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {run,rchg,fc}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expv(input logic [2:0] fc);
    return {(fc == 3'b000), fc[0], fc};
  endfunction

  function automatic logic [4:0] obs();
    return {run_en, recharge_req, fault_code};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; step(1);
      ms_tick = 1'b0; step(1);
    end
  endtask

  task automatic do_reset();
    vs_below_off = 0; vs_above_on = 0; vcc_above_start = 0; gnd_open_det = 0;
    cs_imp_low = 0; startup_stb = 0; maxon_end_stb = 0; ms_tick = 0;
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state", obs(), expv(3'b000));
  endtask

  task automatic t_brownout_entry();
    do_reset();
    vs_below_off = 1; ticks(24); step(1);
    check("R2 no brownout at 24 ticks", obs(), expv(3'b000));
    ticks(1); step(1);
    check("R2 brownout after 25 ticks", obs(), expv(3'b001));
    check("R4 recharge with brownout", {4'b0, recharge_req}, 5'd1);
  endtask

  task automatic t_count_restart();
    do_reset();
    vs_below_off = 1; ticks(24);
    vs_below_off = 0; step(1);
    vs_below_off = 1; ticks(24); step(2);
    check("R3 count restarts on release", obs(), expv(3'b000));
    ticks(1); step(1);
    check("R3 fires on 25th after restart", obs(), expv(3'b001));
  endtask

  task automatic t_exit();
    do_reset();
    vs_below_off = 1; ticks(25); step(1);
    vs_below_off = 0; vs_above_on = 1; step(3);
    check("R5 line high alone keeps brownout", obs(), expv(3'b001));
    vs_above_on = 0; vcc_above_start = 1; step(3);
    check("R5 vcc alone keeps brownout", obs(), expv(3'b001));
    vs_above_on = 1; step(1);
    check("R5 both flags exit brownout", obs(), expv(3'b000));
    check("R4 recharge released", {4'b0, recharge_req}, 5'd0);
  endtask

  task automatic t_gnd();
    do_reset();
    gnd_open_det = 1; ticks(150);
    gnd_open_det = 0; step(1);
    gnd_open_det = 1; ticks(199);
    check("R6 no ground fault at 199 ticks", obs(), expv(3'b000));
    ticks(1);
    check("R6 ground fault at 200 ticks", obs(), expv(3'b010));
    check("R9 run disabled by ground fault", {4'b0, run_en}, 5'd0);
    gnd_open_det = 0; step(1);
    check("R6 ground fault clears", obs(), expv(3'b000));
  endtask

  task automatic t_cs();
    do_reset();
    cs_imp_low = 1; step(5);
    check("R7 unstrobed impedance ignored", obs(), expv(3'b000));
    cs_imp_low = 0; startup_stb = 1; step(1); startup_stb = 0; step(1);
    check("R7 strobe with good impedance", obs(), expv(3'b000));
    cs_imp_low = 1; maxon_end_stb = 1; step(1); maxon_end_stb = 0;
    check("R7 max-on strobe latches short", obs(), expv(3'b100));
    cs_imp_low = 0; vs_above_on = 1; vcc_above_start = 1; ticks(5);
    check("R8 short stays set", obs(), expv(3'b100));
    do_reset();
    check("R8 reset clears short", obs(), expv(3'b000));
    cs_imp_low = 1; startup_stb = 1; step(1); startup_stb = 0; cs_imp_low = 0;
    check("R7 startup strobe latches short", obs(), expv(3'b100));
  endtask

  task automatic t_combined();
    do_reset();
    vs_below_off = 1; gnd_open_det = 1; ticks(200); step(1);
    check("R9 two faults together", obs(), expv(3'b011));
  endtask

  initial begin
    t_reset();
    t_brownout_entry();
    t_count_restart();
    t_exit();
    t_gnd();
    t_cs();
    t_combined();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule